// File: doc/BRIEF.md
# S/PDIF Status-Change Interrupt Controller

This block sits beside an S/PDIF receiver and turns its recovered status into an active-low interrupt. Every cycle it samples seven status flags: the audio-not-PCM flag, the non-PCM sync-detected flag, the copyright-not-asserted flag, the de-emphasis flag, a 2-bit recovered sample-rate code and the clock-recovery unlock flag. It also accepts three single-cycle error pulses: invalid sample, channel-status updated and transmission error.

A change in a flag produces an update event. Each update event and each error pulse can set one sticky bit in an interrupt status register. One mask bit per event can block that event. The interrupt pin is low while any unmasked latched bit is set. Software reaches the block through a simple synchronous register port with read and write strobes. It can read the sampled flags, program the mask, and read the latched events. Reading the latched events clears them.

Top module: `spdif_evt_irq`

## Requirements
- R1: Reset clears the flag snapshot, the mask (reads 00h) and the interrupt status (reads 00h), and holds irq_n_o high.
- R2: The status register at address 0Ch returns the flags sampled on the previous clock edge. Its layout is: bit 0 audio-not-PCM, bit 1 sync detected, bit 2 copyright-not-asserted, bit 3 de-emphasis, bits 5:4 rate code, bit 6 unlock (1 means not locked), bit 7 reads 0.
- R3: The rate code passes unchanged into bits 5:4 of the status register. The codes are 00 = 192 kHz, 01 = 96/88.2 kHz, 10 = 48/44.1 kHz and 11 = 32 kHz.
- R4: A flag change sets its update bit in the interrupt status register on the same edge at which the status register takes the new value. The bits are: bit 0 unlock changed, bit 4 audio-not-PCM or sync flag changed, bit 5 copyright changed, bit 6 de-emphasis changed, bit 7 rate code changed.
- R5: The first flag sample after reset only primes the snapshot and sets no update bit.
- R6: Error pulses set sticky bits: bit 1 invalid, bit 2 channel-status updated, bit 3 transmission error. Latched bits accumulate until they are read.
- R7: While a mask bit (register 0Ah, same bit positions as the interrupt status) is 1, its event neither sets its interrupt status bit nor pulls irq_n_o low.
- R8: irq_n_o is low exactly while some interrupt status bit is 1 and its mask bit is 0. Masking an already latched bit releases the pin, and the bit stays latched.
- R9: A read of address 0Bh returns the interrupt status on reg_rdata_o after the clock edge and clears every bit. An event arriving in the read cycle stays set.
- R10: Writes to 0Ch and 0Bh are ignored. The mask at 0Ah reads back what was written. Reads of any other address return 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| audio_n_i | input | 1 | Recovered audio-not-PCM flag |
| sync_np_i | input | 1 | Non-PCM sync code detected |
| copy_free_i | input | 1 | Copyright-not-asserted flag |
| deemph_i | input | 1 | De-emphasis flag |
| rate_i | input | 2 | Recovered sample-rate code |
| unlock_i | input | 1 | Clock recovery not locked |
| invalid_i | input | 1 | Invalid-sample pulse |
| cs_upd_i | input | 1 | Channel-status-updated pulse |
| tx_err_i | input | 1 | Transmission-error pulse |
| reg_addr_i | input | 8 | Register address |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, valid after the edge of the read |
| irq_n_o | output | 1 | Active-low interrupt |

## Verification
The assertions assume that the flags are synchronous to clk and that the error inputs are single-cycle pulses sampled on the same edge as the flags. They also assume that a read and a write never hit the same address in one cycle. The bench changes every input on the falling edge and raises each error input for exactly one cycle. It holds the flags steady during register accesses, so the only update events it produces are the ones it means to produce. Read and write strobes are never raised together.

// File: rtl/spdif_irq_pkg.sv
package spdif_irq_pkg;

    localparam int EVT_N  = 8;
    localparam int FLAG_W = 7;

    // Event bit positions shared by mask and interrupt status
    localparam int EV_UNLOCK = 0;
    localparam int EV_INVAL  = 1;
    localparam int EV_CSUPD  = 2;
    localparam int EV_TXERR  = 3;
    localparam int EV_NONAUD = 4;
    localparam int EV_COPY   = 5;
    localparam int EV_DEEMPH = 6;
    localparam int EV_RATE   = 7;

    // Packed so that the bit order equals the status register layout
    typedef struct packed {
        logic       unlock;
        logic [1:0] rate;
        logic       deemph;
        logic       copy_free;
        logic       sync_np;
        logic       audio_n;
    } flags_t;

endpackage

// File: rtl/spdif_flag_tracker.sv
module spdif_flag_tracker
    import spdif_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  flags_t           flags_i,
    output flags_t           flags_o,
    output logic [EVT_N-1:0] upd_o
);

    typedef struct packed {
        flags_t snap;
        logic   primed;
    } trk_t;

    trk_t   d, q;
    flags_t diff;

    always_comb begin
        d        = q;
        d.snap   = flags_i;
        d.primed = 1'b1;
        diff     = flags_i ^ q.snap;
        upd_o    = '0;
        if (q.primed) begin
            upd_o[EV_UNLOCK] = diff.unlock;
            upd_o[EV_NONAUD] = diff.audio_n | diff.sync_np;
            upd_o[EV_COPY]   = diff.copy_free;
            upd_o[EV_DEEMPH] = diff.deemph;
            upd_o[EV_RATE]   = |diff.rate;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign flags_o = q.snap;

    // R2: snapshot equals the flags present one edge earlier
    p_snap_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> flags_o == $past(flags_i));

    // R5: no update event before the first sample has been taken
    p_quiet_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !q.primed |-> upd_o == '0);

endmodule

// File: rtl/spdif_irq_latch.sv
module spdif_irq_latch
    import spdif_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_N-1:0] evt_i,
    input  logic [EVT_N-1:0] mask_i,
    input  logic             clr_i,
    output logic [EVT_N-1:0] istat_o,
    output logic             irq_n_o
);

    typedef struct packed {
        logic [EVT_N-1:0] pend;
    } lat_t;

    lat_t             d, q;
    logic [EVT_N-1:0] live;

    always_comb begin
        live   = evt_i & ~mask_i;
        d      = q;
        d.pend = (clr_i ? '0 : q.pend) | live;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign istat_o = q.pend;
    assign irq_n_o = ~|(q.pend & ~mask_i);

    // R7: a masked, clear bit stays clear across the edge
    p_mask_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (istat_o & $past(mask_i & ~istat_o)) == '0);

    // R6: without a clear, latched bits stay latched
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> (istat_o & $past(istat_o)) == $past(istat_o));

    // R4: every unmasked event is latched on the next edge
    p_evt_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (istat_o & $past(evt_i & ~mask_i)) == $past(evt_i & ~mask_i));

endmodule

// File: rtl/spdif_reg_port.sv
module spdif_reg_port #(
    parameter int          ADDR_W     = 8,
    parameter int          DATA_W     = 8,
    parameter logic [7:0]  MASK_ADDR  = 8'h0A,
    parameter logic [7:0]  ISTAT_ADDR = 8'h0B,
    parameter logic [7:0]  STAT_ADDR  = 8'h0C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] stat_i,
    input  logic [DATA_W-1:0] istat_i,
    output logic [DATA_W-1:0] mask_o,
    output logic              clr_o,
    output logic [DATA_W-1:0] rdata_o
);

    localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(MASK_ADDR);
    localparam logic [ADDR_W-1:0] A_ISTAT = ADDR_W'(ISTAT_ADDR);
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(STAT_ADDR);

    typedef struct packed {
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] rdata;
    } rp_t;

    rp_t d, q;

    always_comb begin
        d     = q;
        clr_o = rd_i && (addr_i == A_ISTAT);
        if (wr_i && addr_i == A_MASK) d.mask = wdata_i;
        if (rd_i) begin
            case (addr_i)
                A_MASK:  d.rdata = q.mask;
                A_ISTAT: d.rdata = istat_i;
                A_STAT:  d.rdata = stat_i;
                default: d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mask_o  = q.mask;
    assign rdata_o = q.rdata;

    // R10: only a write to the mask address changes the mask
    p_mask_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && addr_i == A_MASK) |=> $stable(mask_o));

    // R9: an interrupt status read returns the value held at the read
    p_read_val_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_o |=> rdata_o == $past(istat_i));

endmodule

// File: rtl/spdif_evt_irq.sv
module spdif_evt_irq
    import spdif_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       audio_n_i,
    input  logic       sync_np_i,
    input  logic       copy_free_i,
    input  logic       deemph_i,
    input  logic [1:0] rate_i,
    input  logic       unlock_i,
    input  logic       invalid_i,
    input  logic       cs_upd_i,
    input  logic       tx_err_i,
    input  logic [7:0] reg_addr_i,
    input  logic       reg_wr_i,
    input  logic       reg_rd_i,
    input  logic [7:0] reg_wdata_i,
    output logic [7:0] reg_rdata_o,
    output logic       irq_n_o
);

    localparam int DATA_W = EVT_N;

    flags_t            flags_in;
    flags_t            flags_snap;
    logic [EVT_N-1:0]  upd;
    logic [EVT_N-1:0]  evt;
    logic [EVT_N-1:0]  mask;
    logic [EVT_N-1:0]  istat;
    logic              clr;
    logic [DATA_W-1:0] stat_word;

    always_comb begin
        flags_in.unlock    = unlock_i;
        flags_in.rate      = rate_i;
        flags_in.deemph    = deemph_i;
        flags_in.copy_free = copy_free_i;
        flags_in.sync_np   = sync_np_i;
        flags_in.audio_n   = audio_n_i;
        evt                = upd;
        evt[EV_INVAL]      = invalid_i;
        evt[EV_CSUPD]      = cs_upd_i;
        evt[EV_TXERR]      = tx_err_i;
    end

    assign stat_word = DATA_W'(flags_snap);

    spdif_flag_tracker u_trk (
        .clk     (clk),
        .rst_n   (rst_n),
        .flags_i (flags_in),
        .flags_o (flags_snap),
        .upd_o   (upd)
    );

    spdif_irq_latch u_lat (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (evt),
        .mask_i  (mask),
        .clr_i   (clr),
        .istat_o (istat),
        .irq_n_o (irq_n_o)
    );

    spdif_reg_port #(
        .ADDR_W (8),
        .DATA_W (DATA_W)
    ) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (reg_addr_i),
        .wr_i    (reg_wr_i),
        .rd_i    (reg_rd_i),
        .wdata_i (reg_wdata_i),
        .stat_i  (stat_word),
        .istat_i (istat),
        .mask_o  (mask),
        .clr_o   (clr),
        .rdata_o (reg_rdata_o)
    );

    // R4: when the pin falls, the status word already holds the sampled flags
    p_new_flag_visible_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n_o) |-> flags_snap == $past(flags_in));

    // R1: the pin is high on the first edge out of reset
    p_rst_high_r1: assert property (@(posedge clk)
        !rst_n |=> irq_n_o);

endmodule

// File: tb/spdif_evt_irq_tb.sv
module spdif_evt_irq_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] flags = 7'h20;
    logic [2:0] err = 3'b000;
    logic [7:0] addr = 8'h00;
    logic       wr = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq_n;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spdif_evt_irq u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .audio_n_i   (flags[0]),
        .sync_np_i   (flags[1]),
        .copy_free_i (flags[2]),
        .deemph_i    (flags[3]),
        .rate_i      (flags[5:4]),
        .unlock_i    (flags[6]),
        .invalid_i   (err[0]),
        .cs_upd_i    (err[1]),
        .tx_err_i    (err[2]),
        .reg_addr_i  (addr),
        .reg_wr_i    (wr),
        .reg_rd_i    (rd),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_n_o     (irq_n)
    );

    // {flags[6:0], err {tx,cs,inv}, expected interrupt status}
    localparam int NV = 13;
    localparam logic [17:0] VEC [NV] = '{
        {7'h20, 3'b000, 8'h00},
        {7'h21, 3'b000, 8'h10},
        {7'h23, 3'b000, 8'h10},
        {7'h27, 3'b000, 8'h20},
        {7'h2F, 3'b000, 8'h40},
        {7'h3F, 3'b000, 8'h80},
        {7'h7F, 3'b000, 8'h01},
        {7'h7F, 3'b001, 8'h02},
        {7'h7F, 3'b010, 8'h04},
        {7'h7F, 3'b100, 8'h08},
        {7'h00, 3'b111, 8'hFF},
        {7'h00, 3'b000, 8'h00},
        {7'h10, 3'b000, 8'h80}
    };

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%02h exp=%02h", req, got, exp);
        end
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        v = rdata;
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [7:0] v);
        @(negedge clk);
        addr = a; wdata = v; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic step(input logic [6:0] f, input logic [2:0] e);
        @(negedge clk);
        flags = f; err = e;
        @(negedge clk);
        err = 3'b000;
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        chk("R1 irq_n in reset", {7'h0, irq_n}, 8'h01);
        rst_n = 1'b1;
        reg_read(8'h0A, v); chk("R1 mask after reset", v, 8'h00);
        reg_read(8'h0B, v); chk("R5 no event on first sample", v, 8'h00);
        chk("R5 irq_n after priming", {7'h0, irq_n}, 8'h01);
        reg_read(8'h0C, v); chk("R2 status after reset", v, 8'h20);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][17:11], VEC[i][10:8]);
            chk($sformatf("R8 irq_n vec %0d", i), {7'h0, irq_n},
                {7'h0, (VEC[i][7:0] == 8'h00)});
            reg_read(8'h0C, v);
            chk($sformatf("R2 R3 status vec %0d", i), v, {1'b0, VEC[i][17:11]});
            reg_read(8'h0B, v);
            chk($sformatf("R4 R6 R9 istat vec %0d", i), v, VEC[i][7:0]);
        end

        // R7: masked events neither latch nor drive the pin
        reg_write(8'h0A, 8'h12);
        step(7'h11, 3'b001);
        chk("R7 masked irq_n", {7'h0, irq_n}, 8'h01);
        reg_read(8'h0B, v); chk("R7 masked istat", v, 8'h00);
        step(7'h15, 3'b000);
        chk("R7 unmasked irq_n", {7'h0, irq_n}, 8'h00);
        reg_read(8'h0B, v); chk("R7 unmasked istat", v, 8'h20);
        reg_write(8'h0A, 8'h00);

        // R8: masking a latched bit releases the pin, bit stays
        step(7'h15, 3'b100);
        chk("R8 irq low", {7'h0, irq_n}, 8'h00);
        reg_write(8'h0A, 8'h08);
        chk("R8 irq released by mask", {7'h0, irq_n}, 8'h01);
        reg_write(8'h0A, 8'h00);
        chk("R8 irq back after unmask", {7'h0, irq_n}, 8'h00);
        reg_read(8'h0B, v); chk("R8 bit kept", v, 8'h08);
        chk("R9 irq high after read", {7'h0, irq_n}, 8'h01);

        // R9: event in the read cycle survives the clear
        step(7'h15, 3'b010);
        @(negedge clk);
        addr = 8'h0B; rd = 1'b1; err = 3'b001;
        @(negedge clk);
        rd = 1'b0; err = 3'b000;
        chk("R9 read returns old", rdata, 8'h04);
        chk("R9 irq still low", {7'h0, irq_n}, 8'h00);
        reg_read(8'h0B, v); chk("R9 same-cycle event kept", v, 8'h02);

        // R6: bits accumulate until read
        step(7'h15, 3'b001);
        step(7'h15, 3'b100);
        reg_read(8'h0B, v); chk("R6 accumulate", v, 8'h0A);

        // R10: read-only writes ignored, unknown address reads zero
        step(7'h15, 3'b010);
        reg_write(8'h0C, 8'hFF);
        reg_write(8'h0B, 8'hFF);
        reg_read(8'h0C, v); chk("R10 status write ignored", v, 8'h15);
        reg_read(8'h0B, v); chk("R10 istat write ignored", v, 8'h04);
        reg_read(8'h05, v); chk("R10 unknown addr", v, 8'h00);
        reg_write(8'h0A, 8'hA5);
        reg_read(8'h0A, v); chk("R10 mask readback", v, 8'hA5);
        reg_write(8'h0A, 8'h00);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule